// File: doc/BRIEF.md
# Interleaved-Bank Serial Delay Line

This block delays a serial bit stream by a fixed number of cycles (16 by default), like a plain shift register of that length. Internally the storage is split into `NBANK` equal chains, called banks, and each bank advances only once every `NBANK` cycles. A small phase sequencer decides which bank takes each new input sample, so successive samples land in the banks in round-robin order. An output multiplexer picks, in turn, the bank whose last stage holds the oldest sample, which rebuilds the original order on the output.

Each bank sees one shift every `NBANK` cycles instead of one per cycle, so most storage flops stay still on any given edge. Only one bank shifts on each edge. The block uses per-bank shift enables from the phase sequencer, not derived clocks, so every flop stays on the single input clock. `NBANK` may be 1, 2 or 4. With `NBANK = 1` the block is an ordinary chain. `DEPTH` must be a multiple of `NBANK`.

The phase sequencer has one state per bank, numbered 0 to `NBANK-1`. State k means that bank k takes the sample at the next edge and that bank k drives the output now. The only transition is "advance": k goes to k+1, and `NBANK-1` wraps to 0. "Reset" forces state 0 from any state.

Top module: `isr_banked_delay`

## Requirements
- R1: While `rst` is high at a rising edge, every bank and the phase counter clear to zero and `din` is ignored. After release, `dout` reads 0 for the first 15 cycles, until the first sample taken after reset comes out.
- R2: With `NBANK = 1`, a `din` value captured at rising edge k is on `dout` during the cycle that follows edge k+15. That is a delay of 16 cycles, and it holds for every input pattern.
- R3: With `NBANK = 2`, there are two 8-stage banks and each one shifts on every second edge. `dout` has the same 16-cycle delay as in R2.
- R4: With `NBANK = 4`, there are four 4-stage banks and each one shifts on every fourth edge. `dout` has the same 16-cycle delay as in R2.
- R5: The phase counter is 0 after reset. It rises by one on every edge and wraps from `NBANK-1` to 0.
- R6: On each edge exactly one bank captures `din`: the bank whose index equals the phase counter. Every other bank holds its contents.
- R7: `dout` is the last stage of the bank indexed by the phase counter. As a result, a lone 1 in the input shows on `dout` for exactly one cycle, at the 16-cycle delay, whatever phase it entered on.
- R8: A reset asserted while data is in flight throws that data away. After release, `dout` follows the same zero-fill and delay rule as R1, with no old sample reappearing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one input sample per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DW | Serial input sample |
| dout | output | DW | Serial output sample, delayed by DEPTH cycles |

## Verification
Two functions can coincide on one edge: a bank reading out its oldest sample through the multiplexer, and that same bank shifting in a new input sample. Both happen whenever the phase counter points at a bank. A second overlap is a reset arriving while the phase counter is mid-wrap and every bank holds data. The bench provokes the first overlap with lone pulses injected at every phase offset and with dense pseudo-random streams. It judges every output cycle of three instances (1, 2 and 4 banks) against a queue that models a plain 16-stage chain. It provokes the second overlap with a reset in the middle of a random stream, and expects a clean zero fill afterwards.

// File: rtl/isr_pkg.sv
package isr_pkg;

    // Width of a phase index for a given bank count (at least one bit).
    function automatic int phase_width(input int nbank);
        int w;
        w = 1;
        while ((1 << w) < nbank) w++;
        return w;
    endfunction

    // Bank counts the block supports.
    function automatic bit legal_nbank(input int nbank);
        return (nbank == 1) || (nbank == 2) || (nbank == 4);
    endfunction

endpackage

// File: rtl/isr_phase_seq.sv
// Round-robin phase sequencer: one state per bank, a single advance
// transition with wrap, and a reset transition to state 0 (R5).
module isr_phase_seq #(
    parameter int NBANK = 2,
    parameter int PW    = 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [PW-1:0]    phase,
    output logic [NBANK-1:0] bank_en
);

    localparam logic [PW-1:0] LAST = PW'(NBANK - 1);

    logic [PW-1:0] phase_nxt;

    // Next-state logic.
    always_comb begin
        if (phase == LAST) phase_nxt = '0;
        else               phase_nxt = phase + 1'b1;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase_nxt;
    end

    // Output decode: one shift enable per bank (R6).
    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            bank_en[b] = (phase == PW'(b));
        end
    end

endmodule

// File: rtl/isr_bank.sv
// One storage chain; advances only when its shift enable is set.
module isr_bank #(
    parameter int LEN = 8,
    parameter int DW  = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] tail
);

    logic [DW-1:0] stg [LEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LEN; i++) stg[i] <= '0;
        end else if (shift_en) begin
            stg[0] <= din;
            for (int i = 1; i < LEN; i++) stg[i] <= stg[i-1];
        end
    end

    assign tail = stg[LEN-1];

endmodule

// File: rtl/isr_out_mux.sv
// Picks the last stage of the bank named by the phase (R7).
module isr_out_mux #(
    parameter int NBANK = 2,
    parameter int DW    = 1,
    parameter int PW    = 1
) (
    input  logic [NBANK-1:0][DW-1:0] tails,
    input  logic [PW-1:0]            sel,
    output logic [DW-1:0]            dout
);

    always_comb begin
        dout = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (sel == PW'(b)) dout = tails[b];
        end
    end

endmodule

// File: rtl/isr_banked_delay.sv
module isr_banked_delay #(
    parameter int DEPTH = 16,
    parameter int NBANK = 2,
    parameter int DW    = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    localparam int BANK_LEN = DEPTH / NBANK;
    localparam int PW       = isr_pkg::phase_width(NBANK);

    if (!isr_pkg::legal_nbank(NBANK) || (DEPTH % NBANK) != 0) begin : g_bad_cfg
        $error("isr_banked_delay: NBANK must be 1, 2 or 4 and divide DEPTH");
    end

    logic [PW-1:0]            phase;
    logic [NBANK-1:0]         bank_en;
    logic [NBANK-1:0][DW-1:0] bank_tail;

    isr_phase_seq #(.NBANK(NBANK), .PW(PW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .bank_en (bank_en)
    );

    // Sample at edge k goes to bank (k mod NBANK) and reaches its last
    // stage NBANK*(BANK_LEN-1) edges later, then waits there until that
    // bank is selected again, which is exactly the DEPTH-th cycle.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        isr_bank #(.LEN(BANK_LEN), .DW(DW)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .shift_en (bank_en[b]),
            .din      (din),
            .tail     (bank_tail[b])
        );
    end

    // The bank about to capture holds the oldest sample: read it now.
    isr_out_mux #(.NBANK(NBANK), .DW(DW), .PW(PW)) u_mux (
        .tails (bank_tail),
        .sel   (phase),
        .dout  (dout)
    );

endmodule

// File: rtl/isr_banked_delay_chk.sv
module isr_banked_delay_chk #(
    parameter int DEPTH = 16,
    parameter int NBANK = 2,
    parameter int DW    = 1,
    parameter int PW    = isr_pkg::phase_width(NBANK)
) (
    input logic                     clk,
    input logic                     rst,
    input logic [DW-1:0]            din,
    input logic [DW-1:0]            dout,
    input logic [PW-1:0]            phase,
    input logic [NBANK-1:0]         bank_en,
    input logic [NBANK-1:0][DW-1:0] bank_tail
);

    localparam logic [PW-1:0] LAST = PW'(NBANK - 1);

    // Plain single-chain model of the delay.
    logic [DW-1:0] shadow [DEPTH];
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) shadow[i] <= '0;
        end else begin
            shadow[0] <= din;
            for (int i = 1; i < DEPTH; i++) shadow[i] <= shadow[i-1];
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (phase == '0) && (dout == '0));

    // Covers R2 and R4 too, depending on NBANK.
    p_delay_match_r3: assert property (@(posedge clk) disable iff (rst)
        dout == shadow[DEPTH-1]);

    p_phase_step_r5: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) |=> (phase == $past(phase) + 1'b1));

    p_phase_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST) |=> (phase == '0));

    p_one_capture_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(bank_en) == 1);

    for (genvar b = 0; b < NBANK; b++) begin : g_hold
        p_bank_hold_r6: assert property (@(posedge clk) disable iff (rst)
            !bank_en[b] |=> $stable(bank_tail[b]));
    end

endmodule

bind isr_banked_delay isr_banked_delay_chk #(
    .DEPTH (DEPTH),
    .NBANK (NBANK),
    .DW    (DW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .dout      (dout),
    .phase     (phase),
    .bank_en   (bank_en),
    .bank_tail (bank_tail)
);

// File: tb/tb_isr_banked_delay.sv
module tb_isr_banked_delay;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    typedef struct {
        logic  v;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic dout_n1, dout_n2, dout_n4;

    exp_t  sbq[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string cur_tag = "R1";
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    isr_banked_delay #(.DEPTH(DEPTH), .NBANK(1), .DW(1)) dut_n1 (
        .clk(clk), .rst(rst), .din(din), .dout(dout_n1));
    isr_banked_delay #(.DEPTH(DEPTH), .NBANK(2), .DW(1)) dut (
        .clk(clk), .rst(rst), .din(din), .dout(dout_n2));
    isr_banked_delay #(.DEPTH(DEPTH), .NBANK(4), .DW(1)) dut_n4 (
        .clk(clk), .rst(rst), .din(din), .dout(dout_n4));

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: after every non-reset edge, pop one expected item.
    always @(posedge clk) begin
        logic r;
        exp_t e;
        r = rst;
        #(CLK_PERIOD/4);
        if (!r && !done) begin
            if (sbq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2: scoreboard empty, got %b expected item", dout_n1);
            end else begin
                e = sbq.pop_front();
                check1({"R2 ", e.tag, " nbank=1"}, dout_n1, e.v);
                check1({"R3 ", e.tag, " nbank=2"}, dout_n2, e.v);
                check1({"R4 ", e.tag, " nbank=4"}, dout_n4, e.v);
            end
        end
    end

    // Driver: one sample per cycle, expected item pushed alongside.
    task automatic drive(input logic d);
        @(negedge clk);
        din = d;
        sbq.push_back('{v: d, tag: cur_tag});
    endtask

    // Reset with din held high to show it is ignored, then arm the
    // scoreboard with the zero fill seen before the first sample emerges.
    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        din = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check1({tag, " reset state nbank=1"}, dout_n1, 1'b0);
        check1({tag, " reset state nbank=2"}, dout_n2, 1'b0);
        check1({tag, " reset state nbank=4"}, dout_n4, 1'b0);
        sbq.delete();
        for (int i = 0; i < DEPTH - 1; i++) sbq.push_back('{v: 1'b0, tag: tag});
        rst = 1'b0;
        din = 1'b0;
        cur_tag = tag;
        sbq.push_back('{v: 1'b0, tag: tag});
    endtask

    function automatic logic lfsr_bit();
        logic fb;
        fb   = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
        lfsr = {lfsr[14:0], fb};
        return fb;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset("R1");
        for (int i = 0; i < 20; i++) drive(1'b1);

        // Lone pulses entering at every phase offset (R6, R7).
        cur_tag = "R7 R6";
        for (int off = 0; off < 4; off++) begin
            for (int i = 0; i < 20 + off; i++) drive(1'b0);
            drive(1'b1);
        end
        for (int i = 0; i < 24; i++) drive(1'b0);

        // Periodic patterns that alias with the phase wrap (R5).
        cur_tag = "R5";
        for (int i = 0; i < 40; i++) drive(i[0]);
        for (int i = 0; i < 40; i++) drive(i[1]);
        for (int i = 0; i < 40; i++) drive(i % 3 == 0);

        // Dense pseudo-random stream.
        cur_tag = "R6";
        for (int i = 0; i < 300; i++) drive(lfsr_bit());

        // Reset with a full pipeline and mid-cycle phase (R8).
        for (int i = 0; i < 7; i++) drive(1'b1);
        do_reset("R8");
        for (int i = 0; i < 5; i++) drive(1'b1);
        cur_tag = "R8";
        for (int i = 0; i < 100; i++) drive(lfsr_bit());
        for (int i = 0; i < DEPTH + 2; i++) drive(1'b0);

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule